// File: doc/BRIEF.md
# PWM Event Counter with Selectable Count Source

This block is an 8-bit event counter that produces a pulse-width-modulated waveform. A source selector decides what advances the counter. It can step on every system clock cycle, on a prescaled tick whose divide ratio is a power of two, on rising edges of an asynchronous event pin, or on either internal clock gated by that pin's level. The counter always cycles through the values below a programmed period. Whenever it reaches the period it returns to zero, and three things happen on that event: a one-cycle period-end strobe is issued for a downstream accumulator, an event flag is raised, and the waveform returns to its rest level.

A second compare value sets the duty point. When the counter reaches it, the waveform switches to its active level. A polarity bit selects which logic level counts as active. When the output is disabled, the pin rests at its inactive level and the duty compare has no effect, so the unit serves only as a period counter that feeds its strobe to the next stage. Software reaches the block through a small write port and a combinational read port.

Top module: `pwm_event_counter`

## Requirements
- R1: The control register sits at address 0. Its fields are: bits [2:0] source, bits [4:3] prescale exponent, bit 5 polarity, bit 6 output enable, bit 7 interrupt enable. With source 0 the counter advances once per clock cycle. Source values 5 to 7 never advance it.
- R2: With source 1 the counter advances once every 2^exponent clock cycles.
- R3: With source 2 the counter advances once for each rising edge of `ext_evt`, after a two-stage synchronizer. A steady high level adds no further counts.
- R4: Source 3 advances the counter on each clock cycle while the synchronized `ext_evt` is high. Source 4 does the same on each prescaled tick. Neither advances the counter while the pin is low.
- R5: The period register sits at address 1 and holds a nonzero value P. When a count step would bring the counter to P, the counter becomes 0 instead, and `period_strobe` is high for exactly that one cycle. Successive strobes are therefore P count steps apart.
- R6: The flag is bit 0 at address 3. A period match sets it. Writing 1 to it clears it, and writing 0 leaves it unchanged. A match in the same cycle as a clear leaves the flag set. `irq` is the flag ANDed with the interrupt enable.
- R7: The duty register sits at address 2 and holds a value D. With the output enabled and polarity 0, the output goes high in the cycle the counter reaches D and goes low at the period match. If 0 < D < P, the output is high for P−D of every P steps. If D is 0 or D ≥ P, the output stays low.
- R8: Polarity 1 inverts `pwm_out`, so the output is high for D of every P steps when 0 < D < P.
- R9: With the output disabled, `pwm_out` rests at the polarity level. The counter, the strobe and the flag continue to operate.
- R10: A period value of 0 holds the counter at 0. No strobe is issued and the output stays inactive.
- R11: Reads return the register contents, with the flag in bit 0 of address 3. The live counter value is read from address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| ext_evt | input | 1 | Asynchronous external event pin |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Flag ANDed with interrupt enable |
| period_strobe | output | 1 | One-cycle period-end pulse for a cascaded counter |

## Verification
A register write takes effect at the next rising edge, and the counter, waveform, strobe and flag all change on the same edge as the count step that causes them. The bench therefore drives and samples on falling edges, and it reads results one falling edge after the causing stimulus. An external edge appears in the count three rising edges after the pin changes. For this reason the pin tests compare the counter before a burst of pulses with its value several idle cycles after the burst, and do not look at any single cycle. Waveform checks start at one strobe and count high cycles up to the next strobe, so they do not depend on the prescaler's free-running phase or on the count in progress when the configuration changed.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int EXP_W  = 2;

    typedef enum logic [2:0] {
        SRC_SYS       = 3'd0,
        SRC_PRESC     = 3'd1,
        SRC_EDGE      = 3'd2,
        SRC_GATE_SYS  = 3'd3,
        SRC_GATE_PRE  = 3'd4
    } src_e;

    typedef struct packed {
        logic             irq_en;
        logic             out_en;
        logic             pol;
        logic [EXP_W-1:0] exp;
        logic [2:0]       src;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
    localparam logic [ADDR_W-1:0] A_DUTY   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
endpackage

// File: rtl/evt_tick_sel.sv
module evt_tick_sel #(
    parameter int EXP_W  = 2,
    parameter int SYNC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_evt,
    input  logic [2:0]       src_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);
    import pwm_evt_pkg::*;

    localparam int PRE_W = (1 << EXP_W) - 1;

    typedef struct packed {
        logic [SYNC_W-1:0] sync;
        logic              prev;
        logic [PRE_W-1:0]  pre;
    } st_t;

    st_t st_d, st_q;
    logic [PRE_W-1:0] mask;
    logic             presc_tick;
    logic             lvl;
    logic             ext_edge;

    always_comb begin
        mask = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < int'(exp_i)) mask[i] = 1'b1;
        end
        presc_tick = ((st_q.pre & mask) == mask);
        lvl        = st_q.sync[SYNC_W-1];
        ext_edge   = lvl & ~st_q.prev;

        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_W-2:0], ext_evt};
        st_d.prev = lvl;
        st_d.pre  = st_q.pre + 1'b1;

        case (src_i)
            SRC_SYS:      tick_o = 1'b1;
            SRC_PRESC:    tick_o = presc_tick;
            SRC_EDGE:     tick_o = ext_edge;
            SRC_GATE_SYS: tick_o = lvl;
            SRC_GATE_PRE: tick_o = lvl & presc_tick;
            default:      tick_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRESC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_tick && exp_i != '0) |=> (!presc_tick || exp_i == '0)); // R2
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_edge |=> !ext_edge); // R3
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             out_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             out_raw_o,
    output logic             hit_o,
    output logic             strobe_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             strobe;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] nxt;
    logic             p_zero;
    logic             match_p;
    logic             match_d;

    always_comb begin
        nxt     = st_q.cnt + 1'b1;
        p_zero  = (period_i == '0);
        match_p = tick_i && !p_zero && (nxt == period_i);
        match_d = tick_i && !match_p && out_en_i && (nxt == duty_i);

        st_d        = st_q;
        st_d.strobe = match_p;
        if (p_zero)       st_d.cnt = '0;
        else if (match_p) st_d.cnt = '0;
        else if (tick_i)  st_d.cnt = nxt;

        if (!out_en_i || p_zero || match_p) st_d.out = 1'b0;
        else if (match_d)                   st_d.out = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign out_raw_o = st_q.out;
    assign strobe_o  = st_q.strobe;
    assign hit_o     = match_p;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && period_i != '0) |=> $stable(st_q.cnt)); // R1
    AST_STROBE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |-> (st_q.cnt == '0)); // R5
    AST_PERIOD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0) |=> (st_q.cnt == '0 && !st_q.strobe && !st_q.out)); // R10
    AST_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |=> !st_q.out); // R9
endmodule

// File: rtl/pwm_event_counter.sv
module pwm_event_counter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       ext_evt,
    output logic       pwm_out,
    output logic       irq,
    output logic       period_strobe
);
    import pwm_evt_pkg::*;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] period;
        logic [DATA_W-1:0] duty;
        logic              flag;
    } regs_t;

    regs_t r_d, r_q;
    logic              tick;
    logic              hit;
    logic              out_raw;
    logic [DATA_W-1:0] cnt;
    logic              clr_req;

    evt_tick_sel #(.EXP_W(EXP_W), .SYNC_W(2)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_evt(ext_evt),
        .src_i  (r_q.ctrl.src),
        .exp_i  (r_q.ctrl.exp),
        .tick_o (tick)
    );

    evt_count_core #(.CNT_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .period_i (r_q.period),
        .duty_i   (r_q.duty),
        .out_en_i (r_q.ctrl.out_en),
        .cnt_o    (cnt),
        .out_raw_o(out_raw),
        .hit_o    (hit),
        .strobe_o (period_strobe)
    );

    always_comb begin
        r_d     = r_q;
        clr_req = wr_en && (wr_addr == A_STATUS) && wr_data[0];
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:   r_d.ctrl   = ctrl_t'(wr_data);
                A_PERIOD: r_d.period = wr_data;
                A_DUTY:   r_d.duty   = wr_data;
                default:  ;
            endcase
        end
        if (hit)          r_d.flag = 1'b1;
        else if (clr_req) r_d.flag = 1'b0;

        case (rd_addr)
            A_CTRL:   rd_data = r_q.ctrl;
            A_PERIOD: rd_data = r_q.period;
            A_DUTY:   rd_data = r_q.duty;
            A_STATUS: rd_data = {{(DATA_W-1){1'b0}}, r_q.flag};
            A_COUNT:  rd_data = cnt;
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pwm_out = out_raw ^ r_q.ctrl.pol;
    assign irq     = r_q.flag & r_q.ctrl.irq_en;

    AST_FLAG_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        period_strobe |-> r_q.flag); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !clr_req) |=> r_q.flag); // R6
endmodule

// File: tb/pwm_event_counter_bench.sv
`timescale 1ns/1ps
module pwm_event_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_evt = 1'b0;
    logic       pwm_out, irq, period_strobe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_event_counter u_pwm_event_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_evt(ext_evt), .pwm_out(pwm_out), .irq(irq),
        .period_strobe(period_strobe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    function automatic logic [7:0] ctrl(input int src, input int ex, input bit pol,
                                        input bit oen, input bit ien);
        return {ien, oen, pol, ex[1:0], src[2:0]};
    endfunction

    function automatic int exp_high(input int p, input int d, input bit pol, input bit oen);
        int act;
        act = (oen && d != 0 && d < p) ? p - d : 0;
        return pol ? p - act : act;
    endfunction

    task automatic wait_strobe();
        for (int i = 0; i < 3000; i++) begin
            if (period_strobe) return;
            @(negedge clk);
        end
    endtask

    task automatic measure(output int len, output int hi);
        wait_strobe();
        len = 0; hi = 0;
        do begin
            if (pwm_out) hi++;
            len++;
            @(negedge clk);
        end while (!period_strobe && len < 3000);
    endtask

    task automatic count_delta(input int n, output int diff);
        int c0, c1;
        rd(3'd4, c0);
        repeat (n) @(negedge clk);
        rd(3'd4, c1);
        diff = (c1 + 200 - c0) % 200;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v, d, len, hi, p, du;
        bit pol;
        void'($urandom(32'h5EED1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R10, R11)
        rd(3'd0, v); chk(v == 0, "R11 ctrl reset", v, 0);
        rd(3'd4, v); chk(v == 0, "R10 counter held at 0", v, 0);
        chk(pwm_out == 0 && irq == 0 && period_strobe == 0, "R10 outputs idle",
            {pwm_out, irq, period_strobe}, 0);

        // R10: period 0 with system source
        repeat (30) @(negedge clk);
        rd(3'd4, v); chk(v == 0, "R10 counter stays 0", v, 0);
        wr(3'd0, ctrl(7, 0, 0, 1, 0));
        rd(3'd0, v); chk(v == 8'h47, "R11 ctrl readback", v, 8'h47);
        wr(3'd1, 8'd200);
        wr(3'd2, 8'd77);
        rd(3'd1, v); chk(v == 200, "R11 period readback", v, 200);
        rd(3'd2, v); chk(v == 77, "R11 duty readback", v, 77);

        // R1: source 7 never counts; source 0 counts each cycle
        count_delta(20, d); chk(d == 0, "R1 source 7 idle", d, 0);
        wr(3'd0, ctrl(0, 0, 0, 0, 0));
        count_delta(10, d); chk(d == 10, "R1 system clock count", d, 10);

        // R2: prescaled source
        wr(3'd0, ctrl(1, 3, 0, 0, 0));
        count_delta(64, d); chk(d == 8, "R2 divide by 8", d, 8);
        wr(3'd0, ctrl(1, 1, 0, 0, 0));
        count_delta(32, d); chk(d == 16, "R2 divide by 2", d, 16);

        // R3: external edges
        wr(3'd0, ctrl(2, 0, 0, 0, 0));
        repeat (5) @(negedge clk);
        begin
            int c0, c1;
            rd(3'd4, c0);
            for (int k = 0; k < 5; k++) begin
                ext_evt = 1'b1; repeat (3) @(negedge clk);
                ext_evt = 1'b0; repeat (3) @(negedge clk);
            end
            repeat (5) @(negedge clk);
            rd(3'd4, c1);
            d = (c1 + 200 - c0) % 200;
            chk(d == 5, "R3 five edges", d, 5);
        end
        ext_evt = 1'b1; repeat (6) @(negedge clk);
        count_delta(20, d); chk(d == 0, "R3 steady high ignored", d, 0);
        ext_evt = 1'b0; repeat (6) @(negedge clk);

        // R4: gated sources
        wr(3'd0, ctrl(3, 0, 0, 0, 0));
        count_delta(20, d); chk(d == 0, "R4 gate low blocks", d, 0);
        begin
            int c0, c1;
            rd(3'd4, c0);
            ext_evt = 1'b1; repeat (12) @(negedge clk);
            ext_evt = 1'b0; repeat (6) @(negedge clk);
            rd(3'd4, c1);
            d = (c1 + 200 - c0) % 200;
            chk(d == 12, "R4 gated system", d, 12);
            wr(3'd0, ctrl(4, 2, 0, 0, 0));
            rd(3'd4, c0);
            ext_evt = 1'b1; repeat (40) @(negedge clk);
            ext_evt = 1'b0; repeat (6) @(negedge clk);
            rd(3'd4, c1);
            d = (c1 + 200 - c0) % 200;
            chk(d == 10, "R4 gated prescaled", d, 10);
        end

        // R5, R6: period match, flag, irq
        wr(3'd3, 8'h01);
        wr(3'd1, 8'd10);
        wr(3'd0, ctrl(0, 0, 0, 1, 0));
        measure(len, hi);
        rd(3'd4, v); chk(v == 0, "R5 counter 0 at strobe", v, 0);
        measure(len, hi);
        chk(len == 10, "R5 strobe spacing", len, 10);
        rd(3'd3, v); chk(v == 1, "R6 flag set", v, 1);
        chk(irq == 0, "R6 irq masked", irq, 0);
        wr(3'd0, ctrl(0, 0, 0, 1, 1));
        chk(irq == 1, "R6 irq enabled", irq, 1);
        wait_strobe();
        wr(3'd3, 8'h01);
        rd(3'd3, v); chk(v == 0, "R6 write-1 clear", v, 0);
        repeat (8) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        chk(period_strobe == 1, "R6 strobe aligned with clear", period_strobe, 1);
        rd(3'd3, v); chk(v == 1, "R6 set wins over clear", v, 1);
        wr(3'd3, 8'h00);
        rd(3'd3, v); chk(v == 1, "R6 write-0 keeps flag", v, 1);

        // R7, R8, R9: directed waveforms
        wr(3'd1, 8'd20); wr(3'd2, 8'd5);
        measure(len, hi); measure(len, hi);
        chk(hi == 15, "R7 duty 5 of 20", hi, 15);
        wr(3'd2, 8'd0);
        measure(len, hi); measure(len, hi);
        chk(hi == 0, "R7 duty 0 stays low", hi, 0);
        wr(3'd2, 8'd25);
        measure(len, hi); measure(len, hi);
        chk(hi == 0, "R7 duty beyond period", hi, 0);
        wr(3'd2, 8'd5);
        wr(3'd0, ctrl(0, 0, 1, 1, 0));
        measure(len, hi); measure(len, hi);
        chk(hi == 5, "R8 inverted polarity", hi, 5);
        wr(3'd0, ctrl(0, 0, 1, 0, 0));
        measure(len, hi); measure(len, hi);
        chk(hi == 20, "R9 disabled rests at polarity", hi, 20);
        chk(len == 20, "R9 strobe continues", len, 20);

        // R7, R8: random period/duty sweep
        for (int it = 0; it < 12; it++) begin
            p = 2 + int'($urandom % 40);
            du = int'($urandom % (p + 8));
            pol = $urandom % 2;
            wr(3'd1, p[7:0]); wr(3'd2, du[7:0]);
            wr(3'd0, ctrl(0, 0, pol, 1, 0));
            measure(len, hi); measure(len, hi);
            chk(len == p, "R5 random period", len, p);
            chk(hi == exp_high(p, du, pol, 1), pol ? "R8 random duty" : "R7 random duty",
                hi, exp_high(p, du, pol, 1));
        end

        // R10: period returns to 0
        wr(3'd0, ctrl(0, 0, 0, 1, 0));
        wr(3'd1, 8'd0);
        begin
            int seen = 0;
            for (int k = 0; k < 50; k++) begin
                if (period_strobe || pwm_out) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R10 no strobe or output", seen, 0);
        end
        rd(3'd4, v); chk(v == 0, "R10 counter held", v, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule